// File: doc/BRIEF.md
# Storage Key Protection Checker

This block decides whether a storage access may proceed, using a small table of protection metadata kept per 4 KB frame of real storage. Each access presents a real address, a direction (fetch or store), a 4-bit access key, a page-protection flag produced by translation, and a low-address-protection enable. One cycle later the block reports either a grant, or a denial with a reason code. In the same clock edge it records in the frame's entry that the frame was referenced and, for a store, that it was changed.

Each frame entry holds a 4-bit access-control key, a fetch-protect bit, a reference bit and a change bit. A command port lets software overwrite a whole entry in one cycle, or read one back on the following cycle. Only the metadata is modelled. The storage contents are not. Translation, caching and the handling of any resulting interruption belong to neighbouring blocks.

Top module: `skey_guard`

## Requirements
- R1: The frame of an access is `acc_addr[ADDR_W-1:12]`. For an access presented with `acc_valid` high at a clock edge, `acc_done` is high for the following cycle, and `acc_grant` and `acc_reason` carry that access's result during that cycle.
- R2: A store with no page or low-address restriction is granted when the access key is 0 or equals the frame's key. Otherwise it is denied with reason 2'b01 (key violation).
- R3: A fetch is granted when the access key is 0, when it equals the frame's key, or when the frame's fetch-protect bit is clear. A fetch with a nonzero, mismatching key to a fetch-protected frame is denied with reason 2'b01.
- R4: A store with `acc_page_prot` high is denied with reason 2'b10, whatever the key, including key 0. A fetch is unaffected by `acc_page_prot`.
- R5: While `lap_enable` is high, a store to real address 0 through 511 is denied with reason 2'b11, even with key 0. Address 512 is unaffected. With `lap_enable` low, and for fetches, low addresses get no extra restriction.
- R6: When several violations apply, the reason is low-address (2'b11) first, then page (2'b10), then key (2'b01). A grant always carries reason 2'b00.
- R7: A granted access sets the frame's reference bit. A granted store also sets its change bit. A granted fetch leaves the change bit as it was.
- R8: A denied access leaves the frame's reference and change bits unchanged.
- R9: `cmd_set` writes `cmd_wdata` into the addressed entry in one cycle. The bit layout is [6:3] key, [2] fetch-protect, [1] reference, [0] change. `cmd_get` returns the entry on `rd_data`, with `rd_valid` high, on the next cycle.
- R10: After reset, every entry is all zeros and `acc_done` and `rd_valid` are low.
- R11: When `cmd_set` and an access target the same frame in the same cycle, the access is checked against the old entry, the written value is kept, and the access's reference and change update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Real address of the access |
| acc_store | input | 1 | 1 = store, 0 = fetch |
| acc_key | input | 4 | Access key of the requester |
| acc_page_prot | input | 1 | Page-protection flag from translation |
| lap_enable | input | 1 | Low-address protection enable |
| acc_done | output | 1 | Result valid, one cycle after the request |
| acc_grant | output | 1 | Access permitted |
| acc_reason | output | 2 | 00 none, 01 key, 10 page, 11 low-address |
| cmd_set | input | 1 | Write a whole frame entry |
| cmd_get | input | 1 | Read a frame entry |
| cmd_frame | input | ADDR_W-12 | Frame number for the command |
| cmd_wdata | input | 7 | Entry to write: {key, fetch-protect, reference, change} |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 7 | Entry read back, same layout as cmd_wdata |

## Verification
The assertions assume that reset is held for at least two clock edges, so that every $past they use refers to cycles after reset. They also assume the access inputs are defined whenever `acc_valid` is high. The bench drives every input to a known value from time zero, holds reset for several cycles, and changes inputs only on falling edges. The entry-write and change-bit checks assume that the index they sample stays in range, which follows from the frame field being exactly as wide as the table.

// File: rtl/skey_pkg.sv
// Shared types for the storage key protection checker.
// Assumes a 4-bit key and a 7-bit entry layout {key, fprot, refd, chgd}.
package skey_pkg;
    localparam int KEY_W   = 4;
    localparam int ENTRY_W = KEY_W + 3;

    typedef struct packed {
        logic [KEY_W-1:0] acc;
        logic             fprot;
        logic             refd;
        logic             chgd;
    } skey_entry_t;

    typedef enum logic [1:0] {
        RSN_NONE    = 2'b00,
        RSN_KEY     = 2'b01,
        RSN_PAGE    = 2'b10,
        RSN_LOWADDR = 2'b11
    } skey_reason_e;
endpackage

// File: rtl/skey_eval.sv
// Combinational protection decision for one access against one frame entry.
// Assumes the caller supplies the entry of the addressed frame. Applies the
// reason priority low-address > page > key. Page and low-address protection
// apply to stores only.
module skey_eval
    import skey_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LAP_LIMIT = 512
) (
    input  skey_entry_t       entry,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_store,
    input  logic [KEY_W-1:0]  key,
    input  logic              page_prot,
    input  logic              lap_en,
    output logic              grant,
    output skey_reason_e      reason
);
    logic key_ok;
    logic low_hit;

    // Key match: key 0 overrides; a fetch also passes when fetch-protect is clear.
    always_comb begin
        key_ok  = (key == '0) || (key == entry.acc) || (!is_store && !entry.fprot);
        low_hit = lap_en && (addr < ADDR_W'(LAP_LIMIT));
    end

    // Pick the highest-priority violation, or grant.
    always_comb begin
        if (is_store && low_hit)        reason = RSN_LOWADDR;
        else if (is_store && page_prot) reason = RSN_PAGE;
        else if (!key_ok)               reason = RSN_KEY;
        else                            reason = RSN_NONE;
        grant = (reason == RSN_NONE);
    end
endmodule

// File: rtl/skey_array.sv
// Per-frame key table with one combinational lookup port, a reference/change
// update port, a whole-entry write port and a registered read port.
// Assumes a write and an update to the same frame in one cycle resolve in
// favour of the write.
module skey_array
    import skey_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] look_frame,
    output skey_entry_t        look_entry,
    input  logic               upd_en,
    input  logic               upd_store,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  skey_entry_t        wr_data,
    input  logic               rd_en,
    output logic               rd_valid,
    output skey_entry_t        rd_data
);
    localparam int NFRAMES = 1 << FRAME_W;

    skey_entry_t mem [NFRAMES];
    logic        clash;

    // Lookup of the accessed frame and detection of a same-frame write.
    always_comb begin
        look_entry = mem[look_frame];
        clash      = wr_en && (wr_frame == look_frame);
    end

    // Table update: reset clears, write replaces, granted access records use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFRAMES; i++) mem[i] <= '0;
        end else begin
            if (upd_en && !clash) begin
                mem[look_frame].refd <= 1'b1;
                if (upd_store) mem[look_frame].chgd <= 1'b1;
            end
            if (wr_en) mem[wr_frame] <= wr_data;
        end
    end

    // Registered read port, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[wr_frame];
        end
    end

    AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_store && !clash) |=> (mem[$past(look_frame)].chgd && mem[$past(look_frame)].refd)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_frame)] == $past(wr_data))); // R9
endmodule

// File: rtl/skey_guard.sv
// Storage key protection checker top. Looks up the frame of each access,
// evaluates protection, registers the result for one cycle and records
// reference/change on grant. Exposes a set/get command port for the table.
// Assumes ADDR_W > 12 and at most one access per cycle.
module skey_guard
    import skey_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int LAP_LIMIT  = 512,
    localparam int FRAME_W   = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_store,
    input  logic [3:0]         acc_key,
    input  logic               acc_page_prot,
    input  logic               lap_enable,
    output logic               acc_done,
    output logic               acc_grant,
    output logic [1:0]         acc_reason,
    input  logic               cmd_set,
    input  logic               cmd_get,
    input  logic [FRAME_W-1:0] cmd_frame,
    input  logic [6:0]         cmd_wdata,
    output logic               rd_valid,
    output logic [6:0]         rd_data
);
    logic [FRAME_W-1:0] frame;
    skey_entry_t        entry;
    skey_entry_t        rd_entry;
    logic               dec_grant;
    skey_reason_e       dec_reason;

    // Frame number of the access.
    always_comb frame = acc_addr[ADDR_W-1:PAGE_SHIFT];

    skey_array #(.FRAME_W(FRAME_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_frame (frame),
        .look_entry (entry),
        .upd_en     (acc_valid && dec_grant),
        .upd_store  (acc_store),
        .wr_en      (cmd_set),
        .wr_frame   (cmd_frame),
        .wr_data    (skey_entry_t'(cmd_wdata)),
        .rd_en      (cmd_get),
        .rd_valid   (rd_valid),
        .rd_data    (rd_entry)
    );

    skey_eval #(.ADDR_W(ADDR_W), .LAP_LIMIT(LAP_LIMIT)) u_eval (
        .entry     (entry),
        .addr      (acc_addr),
        .is_store  (acc_store),
        .key       (acc_key),
        .page_prot (acc_page_prot),
        .lap_en    (lap_enable),
        .grant     (dec_grant),
        .reason    (dec_reason)
    );

    // Read data in port layout.
    always_comb rd_data = rd_entry;

    // Result register: one cycle from request to decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_done   <= 1'b0;
            acc_grant  <= 1'b0;
            acc_reason <= RSN_NONE;
        end else begin
            acc_done   <= acc_valid;
            acc_grant  <= acc_valid && dec_grant;
            acc_reason <= acc_valid ? dec_reason : RSN_NONE;
        end
    end

    AST_KEY0_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_key == 4'd0 && !acc_page_prot &&
         !(lap_enable && acc_addr < ADDR_W'(LAP_LIMIT))) |=> acc_grant); // R2
    AST_PAGE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_page_prot) |=> (!acc_grant && acc_reason != 2'b00)); // R4
    AST_LOWADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && lap_enable && acc_addr < ADDR_W'(LAP_LIMIT)) |=> (acc_reason == 2'b11)); // R5 R6
    AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> acc_done); // R1
endmodule

// File: tb/skey_guard_test.sv
// Scoreboard bench: driver tasks queue expected results, a monitor pops them.
module skey_guard_test;
    localparam int ADDR_W  = 20;
    localparam int FRAME_W = ADDR_W - 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_valid = 1'b0;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic               acc_store = 1'b0;
    logic [3:0]         acc_key = '0;
    logic               acc_page_prot = 1'b0;
    logic               lap_enable = 1'b0;
    logic               acc_done, acc_grant;
    logic [1:0]         acc_reason;
    logic               cmd_set = 1'b0, cmd_get = 1'b0;
    logic [FRAME_W-1:0] cmd_frame = '0;
    logic [6:0]         cmd_wdata = '0;
    logic               rd_valid;
    logic [6:0]         rd_data;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    logic [2:0] acc_q [$];
    string      acc_tag [$];
    logic [6:0] rd_q [$];
    string      rd_tag [$];

    always #5 clk = ~clk;

    skey_guard uut (.*);

    task automatic chk(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic clr_all();
        acc_valid = 0; cmd_set = 0; cmd_get = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); clr_all(); end
    endtask

    task automatic do_acc(input logic [ADDR_W-1:0] a, input bit st, input logic [3:0] k,
                          input bit pp, input bit lap, input bit g, input logic [1:0] r,
                          input string tag);
        @(negedge clk); clr_all();
        acc_valid = 1; acc_addr = a; acc_store = st; acc_key = k;
        acc_page_prot = pp; lap_enable = lap;
        acc_q.push_back({g, r}); acc_tag.push_back(tag);
    endtask

    task automatic do_set(input int f, input logic [6:0] d);
        @(negedge clk); clr_all();
        cmd_set = 1; cmd_frame = FRAME_W'(f); cmd_wdata = d;
    endtask

    task automatic do_get(input int f, input logic [6:0] e, input string tag);
        @(negedge clk); clr_all();
        cmd_get = 1; cmd_frame = FRAME_W'(f);
        rd_q.push_back(e); rd_tag.push_back(tag);
    endtask

    // Monitor: compare results as they appear.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (acc_done) begin
                if (acc_q.size() == 0) chk(0, "R1", "unexpected acc_done");
                else begin
                    logic [2:0] e;
                    string t;
                    e = acc_q.pop_front(); t = acc_tag.pop_front();
                    chk({acc_grant, acc_reason} == e, t,
                        $sformatf("grant/reason actual %b/%b expected %b/%b",
                                  acc_grant, acc_reason, e[2], e[1:0]));
                end
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) chk(0, "R9", "unexpected rd_valid");
                else begin
                    logic [6:0] e;
                    string t;
                    e = rd_q.pop_front(); t = rd_tag.pop_front();
                    chk(rd_data == e, t, $sformatf("rd_data actual %b expected %b", rd_data, e));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(acc_done == 0 && rd_valid == 0, "R10",
            $sformatf("after reset done/rd_valid actual %b/%b expected 0/0", acc_done, rd_valid));
        do_get(3, 7'b0000_000, "R10");
        // Table contents: {key, fprot, ref, chg}
        do_set(1, 7'b0101_100);
        do_set(2, 7'b0110_000);
        do_set(0, 7'b1001_000);
        do_set(4, 7'b0010_100);
        do_set(255, 7'b1111_100);
        do_get(1, 7'b0101_100, "R9");
        // Key checks on stores and fetches (frame 1 fetch-protected, frame 2 not)
        do_acc(20'h01010, 1, 4'd5, 0, 0, 1, 2'b00, "R2");
        do_acc(20'h01020, 1, 4'd0, 0, 0, 1, 2'b00, "R2");
        do_acc(20'h01030, 1, 4'd3, 0, 0, 0, 2'b01, "R2");
        do_acc(20'h01040, 0, 4'd3, 0, 0, 0, 2'b01, "R3");
        do_acc(20'h02040, 0, 4'd3, 0, 0, 1, 2'b00, "R3");
        do_acc(20'h01050, 0, 4'd0, 0, 0, 1, 2'b00, "R3");
        // Page protection
        do_acc(20'h02000, 1, 4'd6, 1, 0, 0, 2'b10, "R4");
        do_acc(20'h02000, 1, 4'd0, 1, 0, 0, 2'b10, "R4");
        do_acc(20'h02008, 0, 4'd6, 1, 0, 1, 2'b00, "R4");
        // Low-address protection (frame 0, key 9)
        do_acc(20'h001FF, 1, 4'd9, 0, 1, 0, 2'b11, "R5");
        do_acc(20'h00000, 1, 4'd0, 0, 1, 0, 2'b11, "R5");
        do_acc(20'h00200, 1, 4'd9, 0, 1, 1, 2'b00, "R5");
        do_acc(20'h00010, 1, 4'd9, 0, 0, 1, 2'b00, "R5");
        do_acc(20'h00000, 0, 4'd3, 0, 1, 1, 2'b00, "R5");
        // Priority
        do_acc(20'h00100, 1, 4'd3, 1, 1, 0, 2'b11, "R6");
        do_acc(20'h02100, 1, 4'd3, 1, 0, 0, 2'b10, "R6");
        // Highest frame, fetch-protected key 15
        do_acc(20'hFFFFF, 0, 4'd14, 0, 0, 0, 2'b01, "R3");
        do_acc(20'hFFFFF, 0, 4'd15, 0, 0, 1, 2'b00, "R3");
        // Only denied accesses to frame 4
        do_acc(20'h04000, 1, 4'd7, 0, 0, 0, 2'b01, "R8");
        do_acc(20'h04000, 0, 4'd7, 0, 0, 0, 2'b01, "R8");
        do_acc(20'h04000, 1, 4'd2, 1, 0, 0, 2'b10, "R8");
        idle(1);
        // Reference/change recording
        do_get(1, 7'b0101_111, "R7");
        do_get(2, 7'b0110_010, "R7");
        do_get(0, 7'b1001_011, "R7");
        do_get(255, 7'b1111_110, "R7");
        do_get(4, 7'b0010_100, "R8");
        // Same-frame write and access in one cycle
        do_set(5, 7'b0011_000);
        do_acc(20'h05000, 1, 4'd3, 0, 0, 1, 2'b00, "R11");
        cmd_set = 1; cmd_frame = 5; cmd_wdata = 7'b0111_000;
        idle(1);
        do_get(5, 7'b0111_000, "R11");
        idle(4);
        chk(acc_q.size() == 0 && rd_q.size() == 0, "R1",
            $sformatf("pending actual %0d/%0d expected 0/0", acc_q.size(), rd_q.size()));
        finish_run();
    end
endmodule